// File: doc/BRIEF.md
# Machine Check Bank Logger

The block keeps a small set of error-reporting banks. Each bank holds four 64-bit registers: control, status, address and miscellaneous. The block also holds three global registers: capability, global control and global status. An error source presents one injection request per cycle. The request carries a bank index, a bank status word, a global status word, an address, a misc word and an unconditional flag.

The logger first checks whether the request is well formed. It then decides whether the error is dropped, logged or escalated, and updates the selected bank under fixed overwrite and overflow rules. One cycle after the request it returns an acknowledge with a result code. With that acknowledge it may also pulse a machine-check interrupt or a shutdown request.

All registers sit in one indexed space. A write port is used for configuration and for clearing state, and a registered read port returns any register.

Top module: `mcb_logger`

## Requirements
- R1: After reset, inj_ack, mce_irq, shutdown_req and rd_data are 0. Every bank register, the global control and the global status are 0. The capability register holds CAP_RESET, which is 0x104 by default: bank count 4 in bits 7:0 and the control-present flag in bit 8.
- R2: Each cycle with inj_valid high produces inj_ack high in the next cycle, together with inj_result. The result codes are 0 logged, 1 dropped, 2 rejected and 3 shutdown.
- R3: A request is rejected (code 2) and changes no register in any of these cases: the capability register is zero, inj_bank is at least capability bits 7:0, inj_bank is at least NUM_BANKS, or inj_status bit 63 (valid) is clear.
- R4: A request with status bit 55 (action required) clear and inj_uncond low is dropped (code 1) while global status bit 2 (in progress) is set, and no register changes.
- R5: An uncorrected request (status bit 61 set) is dropped (code 1) with no register change in either of two cases. The first is capability bit 8 set while global control is not all ones. The second is the bank's control register not all ones.
- R6: An uncorrected request that passes R3 to R5 while global status bit 2 is set, or while mce_enable is low, returns code 3. It pulses shutdown_req for one cycle with the acknowledge and changes no register.
- R7: Any other uncorrected request is logged (code 0). The bank status becomes inj_status, with bit 62 (overflow) also set if the old status had bit 63 set. The bank address and misc take the request values, global status takes inj_gstatus, and mce_irq pulses with the acknowledge.
- R8: A corrected request (bit 61 clear) replaces the entry if the old status has bit 63 clear or bit 61 clear, and returns code 0. Bit 62 is set when a valid entry was replaced. Global status is unchanged and mce_irq stays low.
- R9: A corrected request that meets an old entry with bits 63 and 61 both set returns code 1. Only bit 62 is set in the old status, and the address and misc are kept.
- R10: Bank n register k sits at index 4n+k, where k is 0 control, 1 status, 2 address and 3 misc. Capability, global control and global status sit at 4*NUM_BANKS plus 0, 1 and 2. rd_data shows the register at rd_idx one cycle later. Indices past the last register read 0. wr_en writes wr_data at wr_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mce_enable | input | 1 | Machine-check enable from the processor control state |
| inj_valid | input | 1 | Injection request strobe |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Bank status word to log |
| inj_gstatus | input | 64 | Global status word for uncorrected errors |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Extra error information |
| inj_uncond | input | 1 | Log action-optional errors even while one is in progress |
| inj_ack | output | 1 | Acknowledge, one cycle after the request |
| inj_result | output | 2 | Result code of the acknowledged request |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register write index |
| wr_data | input | 64 | Register write data |
| rd_idx | input | IDX_W | Register read index |
| rd_data | output | 64 | Registered read data |

## Verification
Requests are sent to empty banks, to banks holding a valid corrected entry and to banks holding a valid uncorrected entry. This separates plain logging from overflow marking and from the blocked corrected case. The same uncorrected request is repeated with the in-progress bit set, with the enable low, with a bank or global control gate closed and with the control-present flag cleared. This shows each rule taking precedence over the ones below it. Invalid status, bank indices at and past the configured count, and a zero capability each give the reject code. Read-back after each request shows that nothing else moved.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int REG_W      = 64;
  localparam int BANK_IDX_W = 8;
  localparam int ST_VAL     = 63;
  localparam int ST_OVER    = 62;
  localparam int ST_UC      = 61;
  localparam int ST_AR      = 55;
  localparam int GS_MCIP    = 2;
  localparam int CAP_CTLP   = 8;

  typedef enum logic [1:0] {
    RES_LOGGED   = 2'd0,
    RES_DROPPED  = 2'd1,
    RES_REJECTED = 2'd2,
    RES_SHUTDOWN = 2'd3
  } mcb_result_e;

  typedef struct packed {
    mcb_result_e      result;
    logic             wr_entry;
    logic             set_over;
    logic             wr_gstat;
    logic             raise_irq;
    logic             raise_shut;
    logic [REG_W-1:0] new_status;
  } mcb_decision_t;
endpackage

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                  req_bank_ok,
  input  logic [BANK_IDX_W-1:0] req_bank,
  input  logic [REG_W-1:0]      req_status,
  input  logic                  req_uncond,
  input  logic [REG_W-1:0]      cap,
  input  logic [REG_W-1:0]      gctl,
  input  logic                  gstat_mcip,
  input  logic [REG_W-1:0]      bank_ctl,
  input  logic [REG_W-1:0]      bank_status,
  input  logic                  mce_enable,
  output mcb_decision_t         dec
);
  logic reject, ao_drop, uc_gate, uc_shut, ce_block;
  logic [REG_W-1:0] over_mask;

  always_comb begin
    reject   = (cap == '0) || (req_bank >= cap[BANK_IDX_W-1:0]) ||
               !req_bank_ok || !req_status[ST_VAL];
    ao_drop  = !req_uncond && !req_status[ST_AR] && gstat_mcip;
    uc_gate  = (cap[CAP_CTLP] && (gctl != '1)) || (bank_ctl != '1);
    uc_shut  = gstat_mcip || !mce_enable;
    ce_block = bank_status[ST_VAL] && bank_status[ST_UC];
    over_mask = '0;
    over_mask[ST_OVER] = bank_status[ST_VAL];

    dec            = '0;
    dec.result     = RES_DROPPED;
    dec.new_status = req_status | over_mask;
    if (reject) begin
      dec.result = RES_REJECTED;
    end else if (ao_drop) begin
      dec.result = RES_DROPPED;
    end else if (req_status[ST_UC]) begin
      if (uc_gate) begin
        dec.result = RES_DROPPED;
      end else if (uc_shut) begin
        dec.result     = RES_SHUTDOWN;
        dec.raise_shut = 1'b1;
      end else begin
        dec.result    = RES_LOGGED;
        dec.wr_entry  = 1'b1;
        dec.wr_gstat  = 1'b1;
        dec.raise_irq = 1'b1;
      end
    end else if (!ce_block) begin
      dec.result   = RES_LOGGED;
      dec.wr_entry = 1'b1;
    end else begin
      dec.result     = RES_DROPPED;
      dec.set_over   = 1'b1;
      dec.new_status = bank_status | (REG_W'(1) << ST_OVER);
    end
  end

  always_comb begin
    if (dec.raise_irq || dec.raise_shut)
      AST_NO_EVENT_ON_REJECT: assert (!reject); // R3
    if (dec.set_over)
      AST_OVER_ONLY_ON_UC_ENTRY: assert (bank_status[ST_UC] && !req_status[ST_UC]); // R9
  end
endmodule

// File: rtl/mcb_regfile.sv
module mcb_regfile
  import mcb_pkg::*;
#(
  parameter int              NUM_BANKS = 4,
  parameter logic [REG_W-1:0] CAP_RESET = 64'h104,
  parameter int              IDX_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  upd_valid,
  input  mcb_decision_t         dec,
  input  logic [BANK_IDX_W-1:0] upd_bank,
  input  logic [REG_W-1:0]      upd_addr,
  input  logic [REG_W-1:0]      upd_misc,
  input  logic [REG_W-1:0]      upd_gstat,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [REG_W-1:0]      rd_data,
  output logic                  sel_ok,
  output logic [REG_W-1:0]      sel_ctl,
  output logic [REG_W-1:0]      sel_status,
  output logic [REG_W-1:0]      cap_q,
  output logic [REG_W-1:0]      gctl_q,
  output logic                  gstat_mcip
);
  localparam int GLOB_BASE = 4 * NUM_BANKS;
  localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [REG_W-1:0] ctl_q  [NUM_BANKS];
  logic [REG_W-1:0] st_q   [NUM_BANKS];
  logic [REG_W-1:0] addr_q [NUM_BANKS];
  logic [REG_W-1:0] misc_q [NUM_BANKS];
  logic [REG_W-1:0] gstat_q;
  logic [SEL_W-1:0] sel;
  logic [REG_W-1:0] rd_mux;

  assign sel_ok     = int'(upd_bank) < NUM_BANKS;
  assign sel        = sel_ok ? upd_bank[SEL_W-1:0] : '0;
  assign sel_ctl    = ctl_q[sel];
  assign sel_status = st_q[sel];
  assign gstat_mcip = gstat_q[GS_MCIP];

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = upd_valid && (upd_bank == BANK_IDX_W'(b));
      always_ff @(posedge clk) begin
        if (rst) begin
          ctl_q[b]  <= '0;
          st_q[b]   <= '0;
          addr_q[b] <= '0;
          misc_q[b] <= '0;
        end else begin
          if (wr_en && wr_idx == IDX_W'(4*b))     ctl_q[b]  <= wr_data;
          if (wr_en && wr_idx == IDX_W'(4*b + 1)) st_q[b]   <= wr_data;
          if (wr_en && wr_idx == IDX_W'(4*b + 2)) addr_q[b] <= wr_data;
          if (wr_en && wr_idx == IDX_W'(4*b + 3)) misc_q[b] <= wr_data;
          if (hit && (dec.wr_entry || dec.set_over)) st_q[b] <= dec.new_status;
          if (hit && dec.wr_entry) begin
            addr_q[b] <= upd_addr;
            misc_q[b] <= upd_misc;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= CAP_RESET;
      gctl_q  <= '0;
      gstat_q <= '0;
    end else begin
      if (wr_en && wr_idx == IDX_W'(GLOB_BASE))     cap_q   <= wr_data;
      if (wr_en && wr_idx == IDX_W'(GLOB_BASE + 1)) gctl_q  <= wr_data;
      if (wr_en && wr_idx == IDX_W'(GLOB_BASE + 2)) gstat_q <= wr_data;
      if (upd_valid && dec.wr_gstat) gstat_q <= upd_gstat;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rd_idx == IDX_W'(4*i))     rd_mux = ctl_q[i];
      if (rd_idx == IDX_W'(4*i + 1)) rd_mux = st_q[i];
      if (rd_idx == IDX_W'(4*i + 2)) rd_mux = addr_q[i];
      if (rd_idx == IDX_W'(4*i + 3)) rd_mux = misc_q[i];
    end
    if (rd_idx == IDX_W'(GLOB_BASE))     rd_mux = cap_q;
    if (rd_idx == IDX_W'(GLOB_BASE + 1)) rd_mux = gctl_q;
    if (rd_idx == IDX_W'(GLOB_BASE + 2)) rd_mux = gstat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  AST_GSTAT_LOADED: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && dec.raise_irq) |=> (gstat_q == $past(upd_gstat))); // R7
  AST_SHUTDOWN_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && dec.raise_shut && !wr_en) |=> $stable(gstat_q)); // R6
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int               NUM_BANKS = 4,
  parameter logic [REG_W-1:0] CAP_RESET = 64'h104,
  parameter int               IDX_W     = $clog2(4*NUM_BANKS + 3)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mce_enable,
  input  logic                  inj_valid,
  input  logic [BANK_IDX_W-1:0] inj_bank,
  input  logic [REG_W-1:0]      inj_status,
  input  logic [REG_W-1:0]      inj_gstatus,
  input  logic [REG_W-1:0]      inj_addr,
  input  logic [REG_W-1:0]      inj_misc,
  input  logic                  inj_uncond,
  output logic                  inj_ack,
  output logic [1:0]            inj_result,
  output logic                  mce_irq,
  output logic                  shutdown_req,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [REG_W-1:0]      rd_data
);
  mcb_decision_t    dec;
  logic             sel_ok, gstat_mcip;
  logic [REG_W-1:0] sel_ctl, sel_status, cap_q, gctl_q;

  mcb_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
    .req_bank_ok (sel_ok),
    .req_bank    (inj_bank),
    .req_status  (inj_status),
    .req_uncond  (inj_uncond),
    .cap         (cap_q),
    .gctl        (gctl_q),
    .gstat_mcip  (gstat_mcip),
    .bank_ctl    (sel_ctl),
    .bank_status (sel_status),
    .mce_enable  (mce_enable),
    .dec         (dec)
  );

  mcb_regfile #(.NUM_BANKS(NUM_BANKS), .CAP_RESET(CAP_RESET), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .upd_valid  (inj_valid),
    .dec        (dec),
    .upd_bank   (inj_bank),
    .upd_addr   (inj_addr),
    .upd_misc   (inj_misc),
    .upd_gstat  (inj_gstatus),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .sel_ok     (sel_ok),
    .sel_ctl    (sel_ctl),
    .sel_status (sel_status),
    .cap_q      (cap_q),
    .gctl_q     (gctl_q),
    .gstat_mcip (gstat_mcip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inj_ack      <= 1'b0;
      inj_result   <= 2'd0;
      mce_irq      <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      inj_ack      <= inj_valid;
      inj_result   <= inj_valid ? 2'(dec.result) : 2'd0;
      mce_irq      <= inj_valid && dec.raise_irq;
      shutdown_req <= inj_valid && dec.raise_shut;
    end
  end

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    inj_valid |=> inj_ack); // R2
  AST_IRQ_MEANS_LOGGED: assert property (@(posedge clk) disable iff (rst)
    mce_irq |-> (inj_ack && inj_result == 2'(RES_LOGGED))); // R7
  AST_SHUT_MEANS_CODE: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> (inj_ack && inj_result == 2'(RES_SHUTDOWN))); // R6
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mce_irq, shutdown_req})); // R6
endmodule

// File: tb/test_mcb_logger.sv
module test_mcb_logger;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int IW = 5;
  localparam int GB = 4 * NB;
  localparam logic [63:0] VAL  = 64'h1 << 63;
  localparam logic [63:0] OVER = 64'h1 << 62;
  localparam logic [63:0] UC   = 64'h1 << 61;
  localparam logic [63:0] AR   = 64'h1 << 55;
  localparam logic [63:0] ONES = '1;

  logic clk = 0, rst = 1, mce_enable = 1;
  logic inj_valid = 0, inj_uncond = 0;
  logic [7:0] inj_bank = 0;
  logic [63:0] inj_status = 0, inj_gstatus = 0, inj_addr = 0, inj_misc = 0;
  logic inj_ack, mce_irq, shutdown_req;
  logic [1:0] inj_result;
  logic wr_en = 0;
  logic [IW-1:0] wr_idx = 0, rd_idx = 0;
  logic [63:0] wr_data = 0, rd_data;
  int total = 0, failed = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcb_logger i_mcb_logger (
    .clk(clk), .rst(rst), .mce_enable(mce_enable), .inj_valid(inj_valid),
    .inj_bank(inj_bank), .inj_status(inj_status), .inj_gstatus(inj_gstatus),
    .inj_addr(inj_addr), .inj_misc(inj_misc), .inj_uncond(inj_uncond),
    .inj_ack(inj_ack), .inj_result(inj_result), .mce_irq(mce_irq),
    .shutdown_req(shutdown_req), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wreg(int idx, logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rreg(string req, string what, int idx, logic [63:0] exp);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    check(req, what, rd_data, exp);
  endtask

  task automatic inject(string req, int bank, logic [63:0] st, logic [63:0] gs,
                        logic [63:0] ad, logic [63:0] mi, bit unc,
                        int exp_res, bit exp_irq, bit exp_shut);
    @(negedge clk);
    inj_valid = 1; inj_bank = 8'(bank); inj_status = st; inj_gstatus = gs;
    inj_addr = ad; inj_misc = mi; inj_uncond = unc;
    @(negedge clk);
    inj_valid = 0;
    check(req, "ack", 64'(inj_ack), 64'd1);
    check(req, "result", 64'(inj_result), 64'(exp_res));
    check(req, "irq", 64'(mce_irq), 64'(exp_irq));
    check(req, "shutdown", 64'(shutdown_req), 64'(exp_shut));
  endtask

  task automatic t_reset();
    check("R1", "ack", 64'(inj_ack), 0);
    check("R1", "irq", 64'(mce_irq), 0);
    check("R1", "shutdown", 64'(shutdown_req), 0);
    check("R1", "rd_data", rd_data, 0);
    rreg("R1", "cap", GB, 64'h104);
    rreg("R1", "gctl", GB + 1, 0);
    rreg("R1", "bank0 status", 1, 0);
    rreg("R1", "bank3 ctl", 12, 0);
  endtask

  task automatic t_setup();
    wreg(GB + 1, ONES);
    for (int b = 0; b < NB; b++) wreg(4*b, ONES);
    rreg("R10", "bank2 ctl written", 8, ONES);
    @(negedge clk);
    check("R2", "no ack when idle", 64'(inj_ack), 0);
  endtask

  task automatic t_reject();
    inject("R3", 0, UC | AR, 0, 1, 1, 0, 2, 0, 0);
    inject("R3", 4, VAL | UC | AR, 0, 1, 1, 0, 2, 0, 0);
    wreg(GB, 64'h102);
    inject("R3", 2, VAL, 0, 1, 1, 0, 2, 0, 0);
    inject("R3", 1, VAL, 0, 5, 5, 0, 0, 0, 0);
    wreg(1 + 4, 0); wreg(2 + 4, 0); wreg(3 + 4, 0);
    wreg(GB, 0);
    inject("R3", 0, VAL | UC | AR, 0, 1, 1, 0, 2, 0, 0);
    wreg(GB, 64'h104);
    rreg("R3", "bank0 status", 1, 0);
    rreg("R3", "bank2 status", 9, 0);
    rreg("R3", "gstat", GB + 2, 0);
  endtask

  task automatic t_uc_log();
    inject("R7", 0, VAL | UC | AR | 64'h11, 64'h5, 64'hA000, 64'hB000, 0, 0, 1, 0);
    rreg("R7", "bank0 status", 1, VAL | UC | AR | 64'h11);
    rreg("R7", "bank0 addr", 2, 64'hA000);
    rreg("R7", "bank0 misc", 3, 64'hB000);
    rreg("R7", "gstat", GB + 2, 64'h5);
  endtask

  task automatic t_in_progress();
    inject("R4", 1, VAL | 64'h3, 0, 1, 1, 0, 1, 0, 0);
    rreg("R4", "bank1 status", 5, 0);
    inject("R6", 1, VAL | UC | AR, 64'h7, 1, 1, 0, 3, 0, 1);
    inject("R6", 1, VAL | UC, 64'h7, 1, 1, 1, 3, 0, 1);
    rreg("R6", "bank1 status", 5, 0);
    rreg("R6", "gstat kept", GB + 2, 64'h5);
    wreg(GB + 2, 0);
    mce_enable = 0;
    inject("R6", 1, VAL | UC | AR, 64'h7, 1, 1, 0, 3, 0, 1);
    mce_enable = 1;
    rreg("R6", "gstat unchanged", GB + 2, 0);
  endtask

  task automatic t_uc_gate();
    wreg(8, 64'h7FFF_FFFF_FFFF_FFFF);
    inject("R5", 2, VAL | UC | AR, 64'h5, 1, 1, 0, 1, 0, 0);
    wreg(8, ONES);
    wreg(GB + 1, 64'hFF);
    inject("R5", 2, VAL | UC | AR, 64'h5, 1, 1, 0, 1, 0, 0);
    rreg("R5", "bank2 status", 9, 0);
    wreg(GB, 64'h4);
    inject("R5", 2, VAL | UC | AR | 64'h22, 64'h5, 64'hC0, 64'hC1, 0, 0, 1, 0);
    rreg("R5", "bank2 status", 9, VAL | UC | AR | 64'h22);
    wreg(GB, 64'h104); wreg(GB + 1, ONES); wreg(GB + 2, 0);
  endtask

  task automatic t_uc_over();
    inject("R7", 0, VAL | UC | AR | 64'h33, 64'h5, 64'hA100, 64'hB100, 0, 0, 1, 0);
    rreg("R7", "bank0 overflow", 1, VAL | OVER | UC | AR | 64'h33);
    rreg("R7", "bank0 addr", 2, 64'hA100);
    wreg(GB + 2, 0);
  endtask

  task automatic t_corrected();
    inject("R8", 3, VAL | 64'h44, 64'h9, 64'hD0, 64'hD1, 0, 0, 0, 0);
    rreg("R8", "bank3 status", 13, VAL | 64'h44);
    rreg("R8", "gstat unchanged", GB + 2, 0);
    inject("R8", 3, VAL | 64'h55, 0, 64'hE0, 64'hE1, 0, 0, 0, 0);
    rreg("R8", "bank3 status over", 13, VAL | OVER | 64'h55);
    rreg("R8", "bank3 addr", 14, 64'hE0);
    rreg("R8", "bank3 misc", 15, 64'hE1);
    inject("R9", 2, VAL | 64'h66, 0, 64'hF0, 64'hF1, 0, 1, 0, 0);
    rreg("R9", "bank2 status", 9, VAL | OVER | UC | AR | 64'h22);
    rreg("R9", "bank2 addr kept", 10, 64'hC0);
    rreg("R9", "bank2 misc kept", 11, 64'hC1);
  endtask

  task automatic t_index();
    rreg("R10", "past last", GB + 3, 0);
    rreg("R10", "index 31", 31, 0);
    wreg(6, 64'h1234);
    rreg("R10", "bank1 addr", 6, 64'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_setup();
    t_reject();
    t_uc_log();
    t_in_progress();
    t_uc_gate();
    t_uc_over();
    t_corrected();
    t_index();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule